// File: doc/BRIEF.md
# Carry-Increment Adder with Growing Groups

This block adds two N-bit operands and a carry-in and returns an N-bit sum and a carry-out. It has no clock and no state. It is the increment form of a carry-select adder. The redundant copies that a select adder keeps are removed:

- One shared stage forms the per-bit generate and propagate terms.
- Each group computes its carries once, assuming a zero carry into the group.
- The real carry into the group is then folded into every bit of the group with one AND-OR term.
- One shared XOR stage forms every sum bit.

The word is split into groups whose widths come from a parameter array. The widths grow from the low end to the high end. This lets the carry into a later group arrive at about the time that group's local carries finish. The widths must add up to N. A mismatch is reported during elaboration.

The block is meant to sit in a datapath wherever a wide combinational adder is needed. The group widths are tuned to the timing of the path it sits on.

Top module: `carry_increment_adder`

## Requirements
- R1: For every input, the value {carry_out, sum} equals opnd_a + opnd_b + carry_in, computed as an unsigned (N+1)-bit value.
- R2: Carry_in acts as a generate one position below bit 0. With both operands zero and carry_in set, the sum is 1 and carry_out is 0.
- R3: With opnd_a all ones, opnd_b zero and carry_in set, the carry passes through every group. The sum is zero and carry_out is 1.
- R4: When every bit of a group propagates (the operand bits differ at each position), the carry leaving that group equals the carry entering it.
- R5: A bit or group prefix never both generates and propagates. When a group's local prefix generates, its outgoing carry is 1 whatever carry enters it. Toggling carry_in then changes no result bit above that group.
- R6: When opnd_b is the bitwise inverse of opnd_a, the sum is all ones and carry_out is 0 if carry_in is 0. The sum is all zeros and carry_out is 1 if carry_in is 1. Alternating patterns (0101... plus 1010...) are one such case.
- R7: With both operands zero and carry_in clear, the sum and carry_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | N | First operand |
| opnd_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of the total |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
The assertions are immediate checks evaluated whenever the combinational logic settles. They assume every input bit holds a defined 0 or 1, and they assume the group-width array sums to N, since elaboration rejects any other array.

The stimulus drives only fully defined operand values, changed once per clock on the inactive edge. This means each comparison sees a settled result. The directed vectors pick patterns that force a whole group to propagate or to generate, so that R4 and R5 are reached and not left to chance.

// File: rtl/cia_pkg.sv
package cia_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Valency-2 merge: upper span hi, lower span lo that is adjacent below it.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/cia_bitwise_pg.sv
module cia_bitwise_pg #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0]       opnd_a,
    input  logic [N-1:0]       opnd_b,
    output cia_pkg::gp_t [N-1:0] bit_gp
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign bit_gp[i].g = opnd_a[i] & opnd_b[i];
        assign bit_gp[i].p = opnd_a[i] ^ opnd_b[i];
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            assert_bit_excl_R5: assert (!(bit_gp[i].g && bit_gp[i].p))
                else $error("bit %0d both generates and propagates", i);
        end
    end
endmodule

// File: rtl/cia_group_prefix.sv
module cia_group_prefix #(
    parameter int unsigned W = 4
) (
    input  cia_pkg::gp_t [W-1:0] bit_gp,
    output cia_pkg::gp_t [W-1:0] pre_gp
);
    import cia_pkg::*;

    // Local prefix assuming zero carry into the group.
    assign pre_gp[0] = bit_gp[0];
    for (genvar i = 1; i < W; i++) begin : g_pre
        assign pre_gp[i] = gp_merge(bit_gp[i], pre_gp[i-1]);
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            assert_prefix_excl_R5: assert (!(pre_gp[i].g && pre_gp[i].p))
                else $error("prefix %0d both generates and propagates", i);
        end
    end
endmodule

// File: rtl/cia_group_increment.sv
module cia_group_increment #(
    parameter int unsigned W = 4
) (
    input  cia_pkg::gp_t [W-1:0] pre_gp,
    input  logic                 grp_cin,
    output logic [W-1:0]         bit_carry,
    output logic                 grp_cout
);
    // Fold the real group carry into each local prefix carry.
    assign bit_carry[0] = grp_cin;
    for (genvar i = 1; i < W; i++) begin : g_inc
        assign bit_carry[i] = pre_gp[i-1].g | (pre_gp[i-1].p & grp_cin);
    end
    assign grp_cout = pre_gp[W-1].g | (pre_gp[W-1].p & grp_cin);

    always_comb begin
        if (pre_gp[W-1].p) begin
            assert_group_pass_R4: assert (grp_cout == grp_cin)
                else $error("propagating group altered its carry");
        end
        if (pre_gp[W-1].g) begin
            assert_group_gen_R5: assert (grp_cout)
                else $error("generating group dropped its carry");
        end
    end
endmodule

// File: rtl/carry_increment_adder.sv
module carry_increment_adder #(
    parameter int unsigned N          = 32,
    parameter int unsigned NUM_GROUPS = 6,
    parameter int unsigned GROUP_SIZES [NUM_GROUPS] = '{2, 3, 4, 5, 6, 12}
) (
    input  logic [N-1:0] opnd_a,
    input  logic [N-1:0] opnd_b,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);
    import cia_pkg::*;

    function automatic int unsigned group_start(input int unsigned grp);
        int unsigned acc = 0;
        for (int unsigned k = 0; k < grp; k++) acc += GROUP_SIZES[k];
        return acc;
    endfunction

    localparam int unsigned TOTAL_WIDTH = group_start(NUM_GROUPS);

    if (TOTAL_WIDTH != N) begin : g_bad_sizes
        $error("group widths sum to %0d, expected %0d", TOTAL_WIDTH, N);
    end

    gp_t  [N-1:0]        bit_gp;
    logic [N-1:0]        carry_d;
    logic [NUM_GROUPS:0] grp_carry_d;
    logic [N-1:0]        sum_d;

    cia_bitwise_pg #(.N(N)) i_bitwise_pg (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .bit_gp (bit_gp)
    );

    assign grp_carry_d[0] = carry_in;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        localparam int unsigned OFF = group_start(g);
        localparam int unsigned W   = GROUP_SIZES[g];
        gp_t [W-1:0] pre_gp;

        cia_group_prefix #(.W(W)) i_prefix (
            .bit_gp (bit_gp[OFF +: W]),
            .pre_gp (pre_gp)
        );

        cia_group_increment #(.W(W)) i_increment (
            .pre_gp    (pre_gp),
            .grp_cin   (grp_carry_d[g]),
            .bit_carry (carry_d[OFF +: W]),
            .grp_cout  (grp_carry_d[g+1])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++) sum_d[i] = bit_gp[i].p ^ carry_d[i];
    end

    assign sum       = sum_d;
    assign carry_out = grp_carry_d[NUM_GROUPS];

    always_comb begin
        assert_sum_matches_R1: assert ({carry_out, sum} ==
                ({1'b0, opnd_a} + {1'b0, opnd_b} + {{N{1'b0}}, carry_in}))
            else $error("sum mismatch");
        if (opnd_a == ~opnd_b) begin
            assert_inverse_ops_R6: assert ({carry_out, sum} == {carry_in, {N{~carry_in}}})
                else $error("inverse operands gave wrong result");
        end
    end
endmodule

// File: tb/test_carry_increment_adder.sv
module test_carry_increment_adder;
    localparam int unsigned N = 32;

    typedef struct {
        logic [N:0] exp;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] opnd_a = '0;
    logic [N-1:0] opnd_b = '0;
    logic         carry_in = 1'b0;
    logic [N-1:0] sum;
    logic         carry_out;

    item_t scb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    carry_increment_adder i_carry_increment_adder (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .sum       (sum),
        .carry_out (carry_out)
    );

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        opnd_a   = a;
        opnd_b   = b;
        carry_in = c;
        it.exp = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c};
        it.tag = tag;
        scb.push_back(it);
    endtask

    always @(posedge clk) begin
        if (!rst && scb.size() > 0) begin
            item_t it;
            it = scb.pop_front();
            checks++;
            if ({carry_out, sum} !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, {carry_out, sum}, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state, zero inputs give zero result
        checks++;
        if ({carry_out, sum} !== '0) begin
            errors++;
            $display("FAIL R7: got %h expected %h", {carry_out, sum}, {(N+1){1'b0}});
        end
        rst = 1'b0;
        drive('0, '0, 1'b0, "R7");
        drive('0, '0, 1'b1, "R2");
        drive('1, '0, 1'b1, "R3");
        drive('0, '1, 1'b1, "R3");
        drive('1, '1, 1'b1, "R1");
        drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b0, "R6");
        drive(32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R6");
        drive(32'h1234_5678, ~32'h1234_5678, 1'b1, "R6");
        // R4: low groups (bits 0..4) all propagate, carry must pass through
        drive(32'h0000_001F, 32'h0000_0000, 1'b1, "R4");
        drive(32'h0000_0015, 32'h0000_000A, 1'b1, "R4");
        // R5: bits 0..1 generate; toggling carry_in touches only bit 0
        drive(32'h0F0F_0003, 32'h00F0_0003, 1'b0, "R5");
        drive(32'h0F0F_0003, 32'h00F0_0003, 1'b1, "R5");
        // R5: a middle group (bits 9..13) generates, upper half unaffected
        drive(32'h0000_3E00 | 32'h8000_01FF, 32'h0000_3E00, 1'b0, "R5");
        drive(32'h0000_3E00 | 32'h8000_01FF, 32'h0000_3E00, 1'b1, "R5");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R1");
        drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, "R1");
        for (int k = 0; k < 300; k++) begin
            drive($urandom, $urandom, 1'($urandom), "R1");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule